// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds one or two independent interval timer channels behind a small word-addressed register bus. Each channel keeps a settings word, a reload value and a live counter. Once started, a channel counts one step per clock, either downward toward zero or upward toward all-ones. When it reaches that end value it raises its expiry flag. It then either stops there or reloads and runs again, whichever its settings word asks for.

Software programs the reload value and then writes the settings word with the start bit set. It waits for the shared interrupt, and acknowledges it by writing a one into the flag bit. All channels share one registered interrupt line. A channel drives that line only while both its flag and its interrupt-enable bit are set. A build parameter selects one or two channels. Every access is a full 32-bit word.

Top module: `interval_timer`

## Requirements
- R1: After reset every settings word, reload value, counter and the interrupt output read zero.
- R2: Channel c, word w sits at word address 4*c+w. Word 0 is the settings word, word 1 is the reload value and word 2 is the live counter. Word 3 and every word of a channel that is not built read zero, and writes to them change nothing.
- R3: The settings word keeps bits 10:0 and reads bits 31:11 as zero. Bit 8 is the expiry flag. A write never sets it. Writing 1 to bit 8 clears it, and writing 0 to bit 8 leaves it unchanged.
- R4: A settings write with bit 7 set copies the reload value into the counter and starts the channel. A settings write with bit 7 clear stops the channel and freezes the counter. Writing the reload value does not change the counter.
- R5: With bit 1 set, a running counter decrements once per clock. Expiry happens at the clock edge at which the counter holds zero.
- R6: With bit 1 clear, a running counter increments once per clock. Expiry happens at the clock edge at which the counter holds all-ones.
- R7: Expiry sets bit 8. With bit 4 clear, the channel then stops with the counter held at its end value.
- R8: With bit 4 set, expiry reloads the counter from the reload value and the channel keeps running. A down-count therefore expires every reload+1 clocks.
- R9: The interrupt output is the OR, over all built channels, of flag AND bit 6 (interrupt enable). It is registered, so it follows a change one clock later.
- R10: A settings write takes the place of that clock's counting step. A flag clear written in a cycle in which the channel would expire therefore takes effect, and no expiry happens at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word address |
| busWe | input | 1 | Write strobe for the addressed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | 1 | Shared, registered interrupt request |

## Verification
The hardest situation to reach from the ports is a flag clear that lands in the same cycle as an expiry. A normal period makes that edge almost impossible to hit with a bus write. The bench therefore programs a reload value of zero with auto-reload, so the channel expires on every clock. Any settings write then collides with an expiry, and the bench checks that the flag reads clear right after that write and set again one clock later. The shared line is exercised by letting one channel raise its flag with interrupts disabled while a second, enabled channel drives and then releases the line.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int WORD_W = 32;
  localparam int CSR_W  = 11;

  // settings word bit positions that carry behaviour
  localparam int CSR_DOWN   = 1;
  localparam int CSR_RELOAD = 4;
  localparam int CSR_IE     = 6;
  localparam int CSR_EN     = 7;
  localparam int CSR_FLAG   = 8;

  typedef enum logic [1:0] {
    REG_CSR   = 2'd0,
    REG_LOAD  = 2'd1,
    REG_COUNT = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wrCsr;
    logic wrLoad;
  } chan_strobe_t;

endpackage

// File: rtl/itmr_regif.sv
module itmr_regif
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWe,
  input  logic [NUM_CH-1:0][CSR_W-1:0]  csrVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  loadVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  countVec,
  output chan_strobe_t [NUM_CH-1:0]     strobeVec,
  output logic [WORD_W-1:0]             busRdata
);

  localparam int CH_IDX_W = ADDR_W - 2;

  logic [CH_IDX_W-1:0] chIdx;
  reg_sel_e            regSel;

  assign chIdx  = busAddr[ADDR_W-1:2];
  assign regSel = reg_sel_e'(busAddr[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    logic hit;
    assign hit = (chIdx == CH_IDX_W'(c));
    assign strobeVec[c].wrCsr  = busWe && hit && (regSel == REG_CSR);
    assign strobeVec[c].wrLoad = busWe && hit && (regSel == REG_LOAD);
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chIdx == CH_IDX_W'(c)) begin
        case (regSel)
          REG_CSR:   busRdata = WORD_W'(csrVec[c]);
          REG_LOAD:  busRdata = WORD_W'(loadVec[c]);
          REG_COUNT: busRdata = WORD_W'(countVec[c]);
          default:   busRdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  chan_strobe_t       strobe,
  input  logic [WORD_W-1:0]  wdata,
  output logic [CSR_W-1:0]   csrOut,
  output logic [CNT_W-1:0]   loadOut,
  output logic [CNT_W-1:0]   countOut,
  output logic               running,
  output logic               irqReq
);

  localparam logic [CSR_W-1:0] FLAG_MASK = CSR_W'(1) << CSR_FLAG;

  logic [CSR_W-1:0] csrReg;   // flag position always held at zero here
  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] count;
  logic             flag;
  logic             run;
  logic             countDown;
  logic             atEnd;

  assign countDown = csrReg[CSR_DOWN];
  assign atEnd     = countDown ? (count == '0) : (count == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrReg  <= '0;
      loadReg <= '0;
      count   <= '0;
      flag    <= 1'b0;
      run     <= 1'b0;
    end else begin
      if (strobe.wrLoad) begin
        loadReg <= wdata[CNT_W-1:0];
      end
      if (strobe.wrCsr) begin
        // a settings write replaces this cycle's counting step
        csrReg <= wdata[CSR_W-1:0] & ~FLAG_MASK;
        if (wdata[CSR_FLAG]) begin
          flag <= 1'b0;
        end
        if (wdata[CSR_EN]) begin
          count <= loadReg;
          run   <= 1'b1;
        end else begin
          run <= 1'b0;
        end
      end else if (run) begin
        if (atEnd) begin
          flag <= 1'b1;
          if (csrReg[CSR_RELOAD]) begin
            count <= loadReg;
          end else begin
            run <= 1'b0;
          end
        end else if (countDown) begin
          count <= count - 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  assign csrOut   = csrReg | (flag ? FLAG_MASK : '0);
  assign loadOut  = loadReg;
  assign countOut = count;
  assign running  = run;
  assign irqReq   = flag && csrReg[CSR_IE];

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);

  chan_strobe_t [NUM_CH-1:0]     strobeVec;
  logic [NUM_CH-1:0][CSR_W-1:0]  csrVec;
  logic [NUM_CH-1:0][CNT_W-1:0]  loadVec;
  logic [NUM_CH-1:0][CNT_W-1:0]  countVec;
  logic [NUM_CH-1:0]             runVec;
  logic [NUM_CH-1:0]             irqReqVec;

  itmr_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .busAddr   (busAddr),
    .busWe     (busWe),
    .csrVec    (csrVec),
    .loadVec   (loadVec),
    .countVec  (countVec),
    .strobeVec (strobeVec),
    .busRdata  (busRdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    itmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobeVec[c]),
      .wdata    (busWdata),
      .csrOut   (csrVec[c]),
      .loadOut  (loadVec[c]),
      .countOut (countVec[c]),
      .running  (runVec[c]),
      .irqReq   (irqReqVec[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= |irqReqVec;
    end
  end

endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            busAddr,
  input logic                         busWe,
  input logic [31:0]                  busWdata,
  input logic [31:0]                  busRdata,
  input logic                         irq,
  input logic [NUM_CH-1:0][CSR_W-1:0] csrVec,
  input logic [NUM_CH-1:0][CNT_W-1:0] loadVec,
  input logic [NUM_CH-1:0][CNT_W-1:0] countVec,
  input logic [NUM_CH-1:0]            runVec
);

  logic csr0Write;
  assign csr0Write = busWe && (busAddr == '0);

  // R2
  spare_word_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] == 2'd3) |-> (busRdata == 32'd0));

  // R3
  csr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] == 2'd0) |-> (busRdata[31:11] == 21'd0));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csr0Write && busWdata[CSR_FLAG]) |=> !csrVec[0][CSR_FLAG]);

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrVec[0][CSR_FLAG] && !(csr0Write && busWdata[CSR_FLAG])) |=> csrVec[0][CSR_FLAG]);

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csr0Write && busWdata[CSR_EN]) |=> (countVec[0] == $past(loadVec[0])));

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runVec[0] && csrVec[0][CSR_DOWN] && (countVec[0] != '0) && !csr0Write)
      |=> (countVec[0] == CNT_W'($past(countVec[0]) - 1'b1)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrVec[0][CSR_FLAG] == 1'b0 && (NUM_CH == 1 || csrVec[NUM_CH-1][CSR_FLAG] == 1'b0))
      |=> !irq);

endmodule

bind interval_timer itmr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irq      (irq),
  .csrVec   (csrVec),
  .loadVec  (loadVec),
  .countVec (countVec),
  .runVec   (runVec)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  logic [2:0]  sAddr = '0;
  logic        sWe = 1'b0;
  logic [31:0] sWdata = '0;
  logic [31:0] sRdata;
  logic        sIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer #(.NUM_CH(2)) u_interval_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  interval_timer #(.NUM_CH(1)) u_singleCh (
    .clk(clk), .rstN(rstN), .busAddr(sAddr), .busWe(sWe),
    .busWdata(sWdata), .busRdata(sRdata), .irq(sIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busWe = 1'b0;
    sWe = 1'b0;
    tick(3);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic wrS(input logic [2:0] a, input logic [31:0] d);
    sAddr = a; sWe = 1'b1; sWdata = d;
    @(posedge clk);
    @(negedge clk);
    sWe = 1'b0; sWdata = '0;
  endtask

  task automatic rdS(input logic [2:0] a, output logic [31:0] v);
    sAddr = a; #1; v = sRdata;
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset word", v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic testCsrStore();
    logic [31:0] v;
    doReset();
    wr(3'd0, 32'hFFFF_FE7F);
    rd(3'd0, v);
    chk("R3 csr keeps 10:0 only", v, 32'h0000_067F);
    wr(3'd0, 32'h0000_0100);
    rd(3'd0, v);
    chk("R3 write cannot set flag", v, 32'd0);
    tick(1);
    chk("R3 no irq from write", {31'd0, irq}, 32'd0);
  endtask

  task automatic testDownOneShot();
    logic [31:0] v;
    doReset();
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h0000_00C2);
    rd(3'd2, v);
    chk("R4 start copies reload", v, 32'd3);
    tick(3);
    rd(3'd2, v);
    chk("R5 down count reaches zero", v, 32'd0);
    rd(3'd0, v);
    chk("R5 no expiry before zero edge", v, 32'h0000_00C2);
    tick(1);
    rd(3'd0, v);
    chk("R7 expiry sets flag", v, 32'h0000_01C2);
    chk("R9 irq one cycle late", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    tick(5);
    rd(3'd2, v);
    chk("R7 stopped at zero", v, 32'd0);
    // flag clear, enable left off
    wr(3'd0, 32'h0000_0142);
    rd(3'd0, v);
    chk("R3 flag cleared by one", v, 32'h0000_0042);
    chk("R9 irq still high this cycle", {31'd0, irq}, 32'd1);
    tick(1);
    chk("R9 irq falls after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic testReload();
    logic [31:0] v;
    doReset();
    wr(3'd1, 32'd2);
    wr(3'd0, 32'h0000_0092);
    tick(3);
    rd(3'd0, v);
    chk("R8 expiry flag with reload", v, 32'h0000_0192);
    rd(3'd2, v);
    chk("R8 counter reloaded", v, 32'd2);
    tick(1);
    rd(3'd2, v);
    chk("R8 keeps running", v, 32'd1);
    tick(2);
    rd(3'd2, v);
    chk("R8 period reload+1", v, 32'd2);
  endtask

  task automatic testUp();
    logic [31:0] v;
    doReset();
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd0, 32'h0000_0080);
    tick(2);
    rd(3'd2, v);
    chk("R6 up count", v, 32'hFFFF_FFFE);
    tick(1);
    rd(3'd0, v);
    chk("R6 no expiry before all-ones edge", v, 32'h0000_0080);
    tick(1);
    rd(3'd0, v);
    chk("R6 expiry at all-ones", v, 32'h0000_0180);
    tick(3);
    rd(3'd2, v);
    chk("R7 up stop holds all-ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic testFreeze();
    logic [31:0] v;
    doReset();
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h0000_0082);
    tick(5);
    rd(3'd2, v);
    chk("R5 five steps down", v, 32'd95);
    wr(3'd1, 32'd5);
    rd(3'd2, v);
    chk("R4 reload write leaves counter", v, 32'd94);
    wr(3'd0, 32'h0000_0002);
    tick(5);
    rd(3'd2, v);
    chk("R4 disable freezes counter", v, 32'd94);
    rd(3'd1, v);
    chk("R4 reload value stored", v, 32'd5);
  endtask

  task automatic testShared();
    logic [31:0] v;
    doReset();
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h0000_0082);
    wr(3'd5, 32'd0);
    wr(3'd4, 32'h0000_00C2);
    tick(1);
    rd(3'd0, v);
    chk("R9 ch0 flag without enable", v, 32'h0000_0182);
    rd(3'd4, v);
    chk("R2 ch1 flag at word 4", v, 32'h0000_01C2);
    tick(1);
    chk("R9 ch1 drives shared irq", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0000_0142);
    tick(1);
    chk("R9 masked ch0 keeps irq low", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h0000_0042);
    rd(3'd0, v);
    chk("R3 zero in bit 8 keeps flag", v, 32'h0000_0142);
    tick(1);
    chk("R9 enabling ch0 raises irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic testUnused();
    logic [31:0] v;
    doReset();
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd3, v);
    chk("R2 spare word reads zero", v, 32'd0);
    for (int a = 0; a < 3; a++) begin
      rd(3'(a), v);
      chk("R2 spare write ignored", v, 32'd0);
    end
    wrS(3'd5, 32'h0000_0055);
    wrS(3'd4, 32'h0000_00C2);
    rdS(3'd4, v);
    chk("R2 absent channel csr zero", v, 32'd0);
    rdS(3'd5, v);
    chk("R2 absent channel reload zero", v, 32'd0);
    rdS(3'd0, v);
    chk("R2 present csr untouched", v, 32'd0);
    rdS(3'd1, v);
    chk("R2 present reload untouched", v, 32'd0);
    tick(3);
    chk("R2 absent channel no irq", {31'd0, sIrq}, 32'd0);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    doReset();
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h0000_0092);
    tick(1);
    rd(3'd0, v);
    chk("R8 zero reload expires each clock", v, 32'h0000_0192);
    wr(3'd0, 32'h0000_0192);
    rd(3'd0, v);
    chk("R10 clear wins over expiry", v, 32'h0000_0092);
    tick(1);
    rd(3'd0, v);
    chk("R10 expiry resumes next edge", v, 32'h0000_0192);
  endtask

  initial begin
    testReset();
    testCsrStore();
    testDownOneShot();
    testReload();
    testUp();
    testFreeze();
    testShared();
    testUnused();
    testCollision();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule